// File: doc/BRIEF.md
# Device Power State Gating Controller

This block sits beside the configuration logic of a PCI-style function and decides how the function's command enables, interrupts, soft reset, bus drivers and clock multiplier behave in each device power state. Software writes a 2-bit power-state value and the command word through one register-write port. The block holds the real command word and gives the bus-interface logic a filtered copy. It collects interrupt events in a pending store, either passes them on or holds them back, and drives a soft reset, a bus-tristate request and a clock-multiplier enable from the current state.

The light sleep state (D2) hides the command enables and the interrupts but keeps them. Both come back when software moves the function to D1 or D0. The deepest software-reachable state (D3hot) keeps a soft reset asserted. That reset wipes the pending interrupts and the stored command word, so nothing comes back on exit. Power removal (D3cold) is seen only as the hard reset input, which returns everything to D0 with the command word and the interrupts cleared.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: While the synchronous hard reset `rst` is high, and on the first cycle after it is released, the state reads D0 (`pstate` = 2'b00), `cmd_eff` is zero, `irq_out` is zero, `soft_rst` and `bus_tristate` are low and `clkmul_en` is high.
- R2: In D0 (2'b00) and D1 (2'b01), a command write (`wr_sel` = 2'd1) makes `cmd_eff` equal to `wr_data` from the next cycle.
- R3: In D2 (2'b10) and D3hot (2'b11), `cmd_eff` bits 0 (I/O space), 1 (memory space), 2 (bus master), 6 (parity error response) and 8 (SERR) read zero whatever the stored value is. All other bits pass through in D2.
- R4: A command write made in D2 updates the stored word but does not change `cmd_eff`. The written value takes effect in the first cycle after leaving to D1 or D0.
- R5: When the state goes from D2 to D1 or D0, the enable bits that were in force before D2 was entered read back again on `cmd_eff`.
- R6: In D2, `irq_out` is zero. A source pulse on `irq_src` during D2 is still latched as pending.
- R7: Interrupts pending when D2 was entered, and those latched during D2, appear on `irq_out` in the first cycle after leaving D2 for D1 or D0.
- R8: For every cycle the state is D3hot, `soft_rst` and `bus_tristate` are high, `irq_out` is zero and the pending store is cleared. Source pulses in D3hot are dropped and do not appear after the state returns to D0.
- R9: Entering D3hot clears the stored command word, and command writes in D3hot are ignored. After the state returns to D0, `cmd_eff` reads zero.
- R10: `clkmul_en` is low exactly in the cycles the state is D3hot and high in every other state.
- R11: A power-state write (`wr_sel` = 2'd0, value in `wr_data[1:0]`) is accepted in any state other than D3hot. In D3hot only a write of D0 is accepted, and writes of D1, D2 or D3hot leave the state at D3hot.
- R12: An acknowledge write (`wr_sel` = 2'd2) clears the pending bits that are set in `wr_data[N_IRQ-1:0]`. A source pulse in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset (models power-up from D3cold) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 power state, 1 command word, 2 interrupt acknowledge |
| wr_data | input | CMD_W | Write data |
| irq_src | input | N_IRQ | Raw interrupt event pulses, one per source |
| pstate | output | 2 | Current power state: 00 D0, 01 D1, 10 D2, 11 D3hot |
| cmd_eff | output | CMD_W | Command word as seen by the bus-interface logic |
| irq_out | output | N_IRQ | Delivered interrupt requests |
| soft_rst | output | 1 | Soft reset, held for the whole time in D3hot |
| bus_tristate | output | 1 | Request to float the attached bus drivers |
| clkmul_en | output | 1 | Clock-multiplier enable |

## Verification
The bench builds the block with its defaults: a 16-bit command word and two interrupt sources. The 16-bit width means the gated bits 6 and 8 exist and the ungated bit 12 is also present, so one test pattern shows masking and pass-through together. With two sources, one interrupt can be pending before D2 while the other arrives inside D2. Both must then come out together on exit, and each can be acknowledged on its own.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

    typedef enum logic [1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pstate_e;

    typedef enum logic [1:0] {
        SEL_PSTATE = 2'd0,
        SEL_CMD    = 2'd1,
        SEL_IRQACK = 2'd2
    } wsel_e;

    // Command bit positions decoded by the bus-interface logic
    localparam int BIT_IO_EN   = 0;
    localparam int BIT_MEM_EN  = 1;
    localparam int BIT_MASTER  = 2;
    localparam int BIT_PAR_RSP = 6;
    localparam int BIT_SERR_EN = 8;
    localparam int MIN_CMD_W   = BIT_SERR_EN + 1;

    // Decoded view of the current and next power state
    typedef struct packed {
        logic gated;      // D2 or D3hot: enables and interrupts hidden
        logic deep;       // D3hot now
        logic deep_next;  // D3hot after this edge
    } pview_t;

    function automatic logic [31:0] gate_mask32();
        logic [31:0] m;
        m = '0;
        m[BIT_IO_EN]   = 1'b1;
        m[BIT_MEM_EN]  = 1'b1;
        m[BIT_MASTER]  = 1'b1;
        m[BIT_PAR_RSP] = 1'b1;
        m[BIT_SERR_EN] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
    import pwr_gate_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ps_wr,
    input  pstate_e ps_val,
    output pstate_e st_q,
    output pview_t  view
);

    pstate_e st_d;
    logic    accept;

    always_comb begin
        accept = ps_wr && ((st_q != PS_D3) || (ps_val == PS_D0));
        st_d   = accept ? ps_val : st_q;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PS_D0;
        else     st_q <= st_d;
    end

    always_comb begin
        view.gated     = (st_q == PS_D2) || (st_q == PS_D3);
        view.deep      = (st_q == PS_D3);
        view.deep_next = (st_d == PS_D3);
    end

    // R11
    d3_exit_only_d0_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_D3 && ps_wr && ps_val != PS_D0) |=> (st_q == PS_D3));

endmodule

// File: rtl/pwr_cmd_store.sv
module pwr_cmd_store
    import pwr_gate_pkg::*;
#(
    parameter int CMD_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  pview_t           view,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_val,
    output logic [CMD_W-1:0] cmd_eff
);

    localparam logic [CMD_W-1:0] GATE = CMD_W'(gate_mask32());

    logic [CMD_W-1:0] cmd_q;

    always_ff @(posedge clk) begin
        if (rst || view.deep_next) cmd_q <= '0;
        else if (cmd_wr && !view.deep) cmd_q <= cmd_val;
    end

    always_comb cmd_eff = view.gated ? (cmd_q & ~GATE) : cmd_q;

    // R9
    d3_cmd_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        view.deep |-> (cmd_q == '0));

    initial begin
        assert (CMD_W >= MIN_CMD_W);
    end

endmodule

// File: rtl/pwr_irq_hold.sv
module pwr_irq_hold
    import pwr_gate_pkg::*;
#(
    parameter int N_IRQ = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  pview_t           view,
    input  logic [N_IRQ-1:0] src,
    input  logic             ack_wr,
    input  logic [N_IRQ-1:0] ack_mask,
    output logic [N_IRQ-1:0] irq_out
);

    logic [N_IRQ-1:0] pend_q;
    logic             wipe;

    always_comb wipe = view.deep || view.deep_next;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst || wipe)                 pend_q[i] <= 1'b0;
            else if (src[i])                 pend_q[i] <= 1'b1;
            else if (ack_wr && ack_mask[i])  pend_q[i] <= 1'b0;
        end
    end

    always_comb irq_out = view.gated ? '0 : pend_q;

    // R12
    pend_no_silent_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_wr && !wipe) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
    import pwr_gate_pkg::*;
#(
    parameter int CMD_W = 16,
    parameter int N_IRQ = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CMD_W-1:0] wr_data,
    input  logic [N_IRQ-1:0] irq_src,
    output logic [1:0]       pstate,
    output logic [CMD_W-1:0] cmd_eff,
    output logic [N_IRQ-1:0] irq_out,
    output logic             soft_rst,
    output logic             bus_tristate,
    output logic             clkmul_en
);

    localparam logic [CMD_W-1:0] GATE = CMD_W'(gate_mask32());

    wsel_e   sel;
    pstate_e st;
    pview_t  view;

    always_comb sel = wsel_e'(wr_sel);

    pwr_state_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .ps_wr  (wr_en && sel == SEL_PSTATE),
        .ps_val (pstate_e'(wr_data[1:0])),
        .st_q   (st),
        .view   (view)
    );

    pwr_cmd_store #(.CMD_W(CMD_W)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .view    (view),
        .cmd_wr  (wr_en && sel == SEL_CMD),
        .cmd_val (wr_data),
        .cmd_eff (cmd_eff)
    );

    pwr_irq_hold #(.N_IRQ(N_IRQ)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .view     (view),
        .src      (irq_src),
        .ack_wr   (wr_en && sel == SEL_IRQACK),
        .ack_mask (wr_data[N_IRQ-1:0]),
        .irq_out  (irq_out)
    );

    always_comb begin
        pstate       = st;
        soft_rst     = view.deep;
        bus_tristate = view.deep;
        clkmul_en    = !view.deep;
    end

    // R3
    d2_enables_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PS_D2) |-> ((cmd_eff & GATE) == '0));

    // R8
    d3_irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (irq_out == '0));

    // R6
    d2_irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == PS_D2) |-> (irq_out == '0));

endmodule

// File: tb/pwr_gate_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_gate_ctrl_tb;

    localparam int CMD_W = 16;
    localparam int N_IRQ = 2;
    localparam logic [CMD_W-1:0] GATE = 16'h0147;

    typedef struct {
        string            tag;
        logic [1:0]       ps;
        logic [CMD_W-1:0] cmd;
        logic [N_IRQ-1:0] irq;
        logic             srst;
        logic             tri_o;
        logic             clk_en;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0;
    logic [CMD_W-1:0] wr_data = '0;
    logic [N_IRQ-1:0] irq_src = '0;
    logic [1:0]       pstate;
    logic [CMD_W-1:0] cmd_eff;
    logic [N_IRQ-1:0] irq_out;
    logic             soft_rst, bus_tristate, clkmul_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    exp_t sb_q[$];

    // spec model state
    logic [1:0]       m_st = 2'b00;
    logic [CMD_W-1:0] m_cmd = '0;
    logic [N_IRQ-1:0] m_pend = '0;

    always #2.5 clk = ~clk;

    pwr_gate_ctrl #(.CMD_W(CMD_W), .N_IRQ(N_IRQ)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_src(irq_src), .pstate(pstate), .cmd_eff(cmd_eff), .irq_out(irq_out),
        .soft_rst(soft_rst), .bus_tristate(bus_tristate), .clkmul_en(clkmul_en)
    );

    // Driver: one call drives one cycle and queues what the outputs should be after the edge
    task automatic step(input string tag, input logic r, input logic we, input logic [1:0] sel,
                        input logic [CMD_W-1:0] d, input logic [N_IRQ-1:0] src);
        exp_t e;
        logic [1:0] nst;
        @(negedge clk);
        rst = r; wr_en = we; wr_sel = sel; wr_data = d; irq_src = src;
        if (r) begin
            m_st = 2'b00; m_cmd = '0; m_pend = '0;
        end else begin
            nst = m_st;
            if (we && sel == 2'd0 && (m_st != 2'b11 || d[1:0] == 2'b00)) nst = d[1:0];
            if (nst == 2'b11) m_cmd = '0;
            else if (we && sel == 2'd1 && m_st != 2'b11) m_cmd = d;
            if (m_st == 2'b11 || nst == 2'b11) m_pend = '0;
            else m_pend = (m_pend & ~((we && sel == 2'd2) ? d[N_IRQ-1:0] : '0)) | src;
            m_st = nst;
        end
        e.tag    = tag;
        e.ps     = m_st;
        e.cmd    = (m_st[1]) ? (m_cmd & ~GATE) : m_cmd;
        e.irq    = (m_st[1]) ? '0 : m_pend;
        e.srst   = (m_st == 2'b11);
        e.tri_o  = (m_st == 2'b11);
        e.clk_en = (m_st != 2'b11);
        sb_q.push_back(e);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 2'd0, '0, '0);
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: samples 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.tag, "pstate", 32'(pstate), 32'(e.ps));
            chk(e.tag, "cmd_eff", 32'(cmd_eff), 32'(e.cmd));
            chk(e.tag, "irq_out", 32'(irq_out), 32'(e.irq));
            chk(e.tag, "soft_rst", 32'(soft_rst), 32'(e.srst));
            chk(e.tag, "bus_tristate", 32'(bus_tristate), 32'(e.tri_o));
            chk(e.tag, "clkmul_en", 32'(clkmul_en), 32'(e.clk_en));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #50000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1 reset state
        step("R1", 1'b1, 1'b0, 2'd0, '0, '0);
        step("R1", 1'b1, 1'b1, 2'd1, 16'hFFFF, 2'b11);
        idle("R1", 1);
        // R2 command in D0 then D1
        step("R2", 1'b0, 1'b1, 2'd1, 16'h1147, '0);
        step("R2", 1'b0, 1'b1, 2'd0, 16'h0001, '0);
        step("R2", 1'b0, 1'b1, 2'd1, 16'h1147, '0);
        // R12 pending, acknowledge, set wins over ack
        step("R12", 1'b0, 1'b0, 2'd0, '0, 2'b01);
        step("R12", 1'b0, 1'b1, 2'd2, 16'h0001, '0);
        step("R12", 1'b0, 1'b1, 2'd2, 16'h0002, 2'b10);
        // R3 R6 enter D2 with source 1 pending
        step("R3", 1'b0, 1'b1, 2'd0, 16'h0002, '0);
        idle("R3", 1);
        step("R6", 1'b0, 1'b0, 2'd0, '0, 2'b01);
        idle("R6", 2);
        // R5 R7 exit to D1: enables and both interrupts return
        step("R5", 1'b0, 1'b1, 2'd0, 16'h0001, '0);
        step("R7", 1'b0, 1'b1, 2'd2, 16'h0003, '0);
        // R4 write inside D2 takes effect on exit to D0
        step("R4", 1'b0, 1'b1, 2'd0, 16'h0002, '0);
        step("R4", 1'b0, 1'b1, 2'd1, 16'h0003, '0);
        idle("R4", 1);
        step("R4", 1'b0, 1'b1, 2'd0, 16'h0000, '0);
        // R8 R9 R10 enter D3 with a pending interrupt
        step("R8", 1'b0, 1'b1, 2'd1, 16'h0147, 2'b10);
        step("R9", 1'b0, 1'b1, 2'd0, 16'h0003, '0);
        step("R8", 1'b0, 1'b0, 2'd0, '0, 2'b11);
        step("R9", 1'b0, 1'b1, 2'd1, 16'hFFFF, '0);
        // R11 writes other than D0 ignored in D3
        step("R11", 1'b0, 1'b1, 2'd0, 16'h0001, '0);
        step("R11", 1'b0, 1'b1, 2'd0, 16'h0002, '0);
        step("R10", 1'b0, 1'b0, 2'd0, '0, '0);
        // leave D3 for D0: nothing restored, nothing delivered
        step("R9", 1'b0, 1'b1, 2'd0, 16'h0000, '0);
        idle("R8", 2);
        step("R2", 1'b0, 1'b1, 2'd1, 16'h0005, '0);
        // R1 hard reset mid-operation
        step("R1", 1'b0, 1'b1, 2'd0, 16'h0002, 2'b01);
        step("R1", 1'b1, 1'b0, 2'd0, '0, '0);
        idle("R1", 2);
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule